// File: doc/BRIEF.md
# Command-Response Buffer Controller

This block is the device-side control engine for a shared-buffer command interface. A host first claims a locality through a control/state register pair. It then moves the engine from idle to ready with a request register, places a command in a memory-mapped data buffer and writes a start register. The engine keeps the idle, ready and executing state. It drives a busy line to an external executor and ends execution when that executor pulses a completion input. At that point it writes a fixed-format response header into the buffer. A cancel register lets the host abort a running command. Illegal start attempts raise an error flag.

State changes requested by the host are not immediate. Granting locality takes `LOC_LAT` cycles and each idle/ready transition takes `STATE_LAT` cycles, so host polling loops are exercised. Request bits read back as 1 while their transition is in flight and self-clear when it completes. The start register reads 1 for the whole execution. Read-only registers describe the buffer: one unified region whose command and response addresses match and whose sizes are equal.

Top module: `crb_engine`

## Requirements
- R1: After reset, locality state (0x00) reads 0x80, status (0x44) reads 0x2, and request (0x40), start (0x4C) and cancel (0x48) read 0.
- R2: Writing bit0=1 to locality control (0x08) sets locality state to 0x82 (bit1 assigned, bit7 valid) exactly `LOC_LAT` cycles after the write, and locality status (0x0C) bit0 then reads 1. Writing bit1=1 releases locality on the next cycle, and the state reads 0x80 again.
- R3: While locality is not assigned, writes to request, start, cancel and the data buffer have no effect and do not set the error bit.
- R4: Writing request bit0 (go-ready) in idle clears status bit1 (idle) on the next cycle. Request bit0 reads 1 for `STATE_LAT` cycles and then reads 0 once ready is reached.
- R5: Writing request bit1 (go-idle) in ready makes request bit1 read 1 for `STATE_LAT` cycles. Then status reads 0x2: idle set and status bit0 (error) cleared. Go-idle written while already idle clears the error bit at once.
- R6: Writing start bit0=1 in ready makes start read 1 and raises `exec_busy` until the cycle after `exec_done`. After that, start reads 0 and the engine is ready again.
- R7: A start write while not ready (idle, in transition or executing) does not start execution and sets status bit0 (error).
- R8: Cancel holds the last written bit0, and `exec_cancel` mirrors it. While it is 1 during execution, execution ends on the next cycle, start reads 0 and no response header is written.
- R9: On completion the buffer holds a 10-byte header, with buffer byte n stored in byte lane n mod 4 of word n/4. Bytes 0-1 hold `RSP_TAG`, bytes 2-5 hold the big-endian length 10, and bytes 6-9 hold `exec_rc` big-endian. Bytes 10-11 are left unchanged.
- R10: Data buffer word i sits at byte address 0x80+4*i. It is written only when locality is assigned and can be read at any time.
- R11: Command and response address low registers (0x5C, 0x68) both read `DEV_BASE`+0x80, and the high registers (0x60, 0x6C) read 0. The size registers (0x58, 0x64) both read 4*`BUF_WORDS`, and the interface ID register (0x30) reads `IF_ID`.
- R12: A go-idle write during execution is ignored: request reads 0 and execution continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| exec_busy | output | 1 | High while a command executes |
| exec_cancel | output | 1 | Current cancel register value |
| exec_done | input | 1 | One-cycle completion pulse from the executor |
| exec_rc | input | 32 | Return code captured with `exec_done` |

## Verification
Read data is registered, so a read returns the state left by the previous clock edge. For a write accepted at edge k, reads at edges k+1 to k+LAT still show the transition in flight. The read at edge k+LAT+1 shows the new state. The bench issues reads back to back right after each go-ready, go-idle and locality request, and checks the exact read index at which each bit flips. After `exec_done` or a cancel write, the start register is checked on the second read, and the header words are read only after that.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int DW = 32;

    // Register byte offsets; the host software decodes these positions.
    localparam int OFF_LOC_STATE = 'h00;
    localparam int OFF_LOC_CTRL  = 'h08;
    localparam int OFF_LOC_STS   = 'h0C;
    localparam int OFF_IF_ID     = 'h30;
    localparam int OFF_REQ       = 'h40;
    localparam int OFF_STS       = 'h44;
    localparam int OFF_CANCEL    = 'h48;
    localparam int OFF_START     = 'h4C;
    localparam int OFF_CMD_SIZE  = 'h58;
    localparam int OFF_CMD_LO    = 'h5C;
    localparam int OFF_CMD_HI    = 'h60;
    localparam int OFF_RSP_SIZE  = 'h64;
    localparam int OFF_RSP_LO    = 'h68;
    localparam int OFF_RSP_HI    = 'h6C;
    localparam int OFF_BUF       = 'h80;

    localparam int          HDR_BYTES   = 10;
    localparam logic [31:0] RSP_HDR_LEN = 32'd10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TO_READY,
        ST_READY,
        ST_EXEC,
        ST_TO_IDLE
    } ctrl_state_e;

    // Word w of the response header; byte n lives in lane n%4 of word n/4.
    function automatic logic [31:0] rsp_hdr_word(input int unsigned w,
                                                 input logic [15:0] tag,
                                                 input logic [31:0] rc);
        logic [79:0] hdr;
        logic [31:0] o;
        hdr = {tag, RSP_HDR_LEN, rc};
        o   = '0;
        for (int b = 0; b < 4; b++) begin
            if (4 * w + b < HDR_BYTES) begin
                o[8*b +: 8] = hdr[79 - 8*(4*w + b) -: 8];
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/crb_locality.sv
module crb_locality #(
    parameter int LOC_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_bits,
    output logic       granted
);
    localparam int CW = (LOC_LAT > 1) ? $clog2(LOC_LAT) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(LOC_LAT - 1);

    typedef struct packed {
        logic          granted;
        logic          pending;
        logic [CW-1:0] cnt;
    } loc_t;

    loc_t loc_d, loc_q;

    always_comb begin
        loc_d = loc_q;
        if (loc_q.pending) begin
            if (loc_q.cnt == '0) begin
                loc_d.pending = 1'b0;
                loc_d.granted = 1'b1;
            end else begin
                loc_d.cnt = loc_q.cnt - 1'b1;
            end
        end
        if (ctrl_wr) begin
            if (ctrl_bits[1]) begin
                loc_d.granted = 1'b0;
                loc_d.pending = 1'b0;
            end else if (ctrl_bits[0] && !loc_q.granted && !loc_q.pending) begin
                loc_d.pending = 1'b1;
                loc_d.cnt     = CNT_INIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) loc_q <= '0;
        else        loc_q <= loc_d;
    end

    assign granted = loc_q.granted;

    // R2
    grant_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_q.granted) |-> $past(loc_q.pending));

    // R2
    release_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_bits[1]) |=> !loc_q.granted);

endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
    import crb_pkg::*;
#(
    parameter int STATE_LAT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        loc_ok,
    input  logic        req_wr,
    input  logic        start_wr,
    input  logic        cancel_wr,
    input  logic [1:0]  wbits,
    input  logic        exec_done,
    output ctrl_state_e state,
    output logic        err,
    output logic        cancel,
    output logic        hdr_we
);
    localparam int CW = (STATE_LAT > 1) ? $clog2(STATE_LAT) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(STATE_LAT - 1);

    typedef struct packed {
        ctrl_state_e   st;
        logic [CW-1:0] cnt;
        logic          err;
        logic          cancel;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  hdr_we_d;
    logic  go_ready, go_idle, go_start;

    assign go_ready = req_wr   && loc_ok && wbits[0];
    assign go_idle  = req_wr   && loc_ok && wbits[1];
    assign go_start = start_wr && loc_ok && wbits[0];

    always_comb begin
        ctl_d    = ctl_q;
        hdr_we_d = 1'b0;
        if (cancel_wr && loc_ok) ctl_d.cancel = wbits[0];
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (go_ready) begin
                    ctl_d.st  = ST_TO_READY;
                    ctl_d.cnt = CNT_INIT;
                end else if (go_idle) begin
                    ctl_d.err = 1'b0;
                end
            end
            ST_TO_READY: begin
                if (ctl_q.cnt == '0) ctl_d.st  = ST_READY;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            ST_READY: begin
                if (go_start) begin
                    ctl_d.st = ST_EXEC;
                end else if (go_idle) begin
                    ctl_d.st  = ST_TO_IDLE;
                    ctl_d.cnt = CNT_INIT;
                end
            end
            ST_EXEC: begin
                if (ctl_q.cancel) begin
                    ctl_d.st = ST_READY;
                end else if (exec_done) begin
                    ctl_d.st = ST_READY;
                    hdr_we_d = 1'b1;
                end
            end
            ST_TO_IDLE: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.err = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (go_start && ctl_q.st != ST_READY) ctl_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.cnt    <= '0;
            ctl_q.err    <= 1'b0;
            ctl_q.cancel <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state  = ctl_q.st;
    assign err    = ctl_q.err;
    assign cancel = ctl_q.cancel;
    assign hdr_we = hdr_we_d;

    // R6
    exec_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.st == ST_EXEC) |-> $past(exec_done || ctl_q.cancel));

    // R7
    bad_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && loc_ok && wbits[0] && ctl_q.st != ST_READY) |=> ctl_q.err);

    // R5
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.err) |-> (ctl_q.st == ST_IDLE));

    // R3
    no_loc_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_wr && !loc_ok) |=> $stable(ctl_q.cancel));

    // R12
    exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_EXEC && !ctl_q.cancel && !exec_done) |=> (ctl_q.st == ST_EXEC));

endmodule

// File: rtl/crb_buffer.sv
module crb_buffer
    import crb_pkg::*;
#(
    parameter int          BUF_WORDS = 16,
    parameter logic [15:0] RSP_TAG   = 16'h8001,
    localparam int         IW        = $clog2(BUF_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [IW-1:0] host_idx,
    input  logic [31:0]   host_data,
    input  logic          hdr_we,
    input  logic [31:0]   hdr_rc,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data
);
    localparam int HDR_WORDS = (HDR_BYTES + 3) / 4;
    localparam int LAST_LANES = HDR_BYTES - 4 * (HDR_WORDS - 1);

    typedef struct packed {
        logic [BUF_WORDS-1:0][31:0] mem;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [HDR_WORDS-1:0][31:0] hdr_words;

    for (genvar w = 0; w < HDR_WORDS; w++) begin : g_hdr
        assign hdr_words[w] = rsp_hdr_word(w, RSP_TAG, hdr_rc);
    end

    always_comb begin
        buf_d = buf_q;
        if (host_we) buf_d.mem[host_idx] = host_data;
        if (hdr_we) begin
            for (int w = 0; w < HDR_WORDS; w++) begin
                for (int b = 0; b < 4; b++) begin
                    if (w < HDR_WORDS - 1 || b < LAST_LANES) begin
                        buf_d.mem[w][8*b +: 8] = hdr_words[w][8*b +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign rd_data = buf_q.mem[rd_idx];

    // R9
    hdr_tail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_we && !host_we) |=> $stable(buf_q.mem[HDR_WORDS-1][31:8*LAST_LANES]));

endmodule

// File: rtl/crb_engine.sv
module crb_engine
    import crb_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          BUF_WORDS = 16,
    parameter int          STATE_LAT = 4,
    parameter int          LOC_LAT   = 2,
    parameter logic [31:0] IF_ID     = 32'h0001_5A17,
    parameter logic [31:0] DEV_BASE  = 32'hFED4_0000,
    parameter logic [15:0] RSP_TAG   = 16'h8001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              exec_busy,
    output logic              exec_cancel,
    input  logic              exec_done,
    input  logic [31:0]       exec_rc
);
    localparam int          IW        = $clog2(BUF_WORDS);
    localparam int          BUF_BYTES = 4 * BUF_WORDS;
    localparam logic [31:0] BUF_ADDR  = DEV_BASE + 32'(OFF_BUF);

    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    logic              granted, err, cancel, hdr_we;
    ctrl_state_e       state;
    logic [ADDR_W-1:0] buf_off;
    logic              in_buf;
    logic [31:0]       buf_rd;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    assign buf_off = reg_addr - ADDR_W'(OFF_BUF);
    assign in_buf  = (reg_addr >= ADDR_W'(OFF_BUF)) && (buf_off < ADDR_W'(BUF_BYTES));

    crb_locality #(.LOC_LAT(LOC_LAT)) u_loc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (reg_wr && hit(reg_addr, OFF_LOC_CTRL)),
        .ctrl_bits (reg_wdata[1:0]),
        .granted   (granted)
    );

    crb_ctrl #(.STATE_LAT(STATE_LAT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_ok    (granted),
        .req_wr    (reg_wr && hit(reg_addr, OFF_REQ)),
        .start_wr  (reg_wr && hit(reg_addr, OFF_START)),
        .cancel_wr (reg_wr && hit(reg_addr, OFF_CANCEL)),
        .wbits     (reg_wdata[1:0]),
        .exec_done (exec_done),
        .state     (state),
        .err       (err),
        .cancel    (cancel),
        .hdr_we    (hdr_we)
    );

    crb_buffer #(.BUF_WORDS(BUF_WORDS), .RSP_TAG(RSP_TAG)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (reg_wr && in_buf && granted),
        .host_idx  (buf_off[IW+1:2]),
        .host_data (reg_wdata),
        .hdr_we    (hdr_we),
        .hdr_rc    (exec_rc),
        .rd_idx    (buf_off[IW+1:2]),
        .rd_data   (buf_rd)
    );

    always_comb begin
        rd_d = rd_q;
        if (reg_rd) begin
            rd_d.rdata = '0;
            if (in_buf) begin
                rd_d.rdata = buf_rd;
            end else begin
                unique case (1'b1)
                    hit(reg_addr, OFF_LOC_STATE): rd_d.rdata = {24'd0, 1'b1, 5'd0, granted, 1'b0};
                    hit(reg_addr, OFF_LOC_STS):   rd_d.rdata = {31'd0, granted};
                    hit(reg_addr, OFF_IF_ID):     rd_d.rdata = IF_ID;
                    hit(reg_addr, OFF_REQ):       rd_d.rdata = {30'd0, state == ST_TO_IDLE, state == ST_TO_READY};
                    hit(reg_addr, OFF_STS):       rd_d.rdata = {30'd0, state == ST_IDLE, err};
                    hit(reg_addr, OFF_CANCEL):    rd_d.rdata = {31'd0, cancel};
                    hit(reg_addr, OFF_START):     rd_d.rdata = {31'd0, state == ST_EXEC};
                    hit(reg_addr, OFF_CMD_SIZE),
                    hit(reg_addr, OFF_RSP_SIZE):  rd_d.rdata = 32'(BUF_BYTES);
                    hit(reg_addr, OFF_CMD_LO),
                    hit(reg_addr, OFF_RSP_LO):    rd_d.rdata = BUF_ADDR;
                    default:                      rd_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata   = rd_q.rdata;
    assign exec_busy   = (state == ST_EXEC);
    assign exec_cancel = cancel;

    // R3
    no_loc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit(reg_addr, OFF_START) && !granted && !exec_busy) |=> !exec_busy);

    // R6
    busy_needs_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exec_busy) |-> $past(granted));

endmodule

// File: tb/crb_engine_test.sv
`timescale 1ns/1ps
module crb_engine_test;
    localparam int          SLAT  = 5;
    localparam int          LLAT  = 3;
    localparam int          WORDS = 16;
    localparam logic [31:0] IFID  = 32'h0001_5A17;
    localparam logic [31:0] BASE  = 32'hFED4_0000;
    localparam logic [15:0] TAG   = 16'h8001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        exec_busy, exec_cancel;
    logic        exec_done = 1'b0;
    logic [31:0] exec_rc = '0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] model [WORDS];

    always #4 clk = ~clk;

    crb_engine #(
        .ADDR_W(12), .BUF_WORDS(WORDS), .STATE_LAT(SLAT), .LOC_LAT(LLAT),
        .IF_ID(IFID), .DEV_BASE(BASE), .RSP_TAG(TAG)
    ) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .exec_busy(exec_busy), .exec_cancel(exec_cancel),
        .exec_done(exec_done), .exec_rc(exec_rc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the following posedge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // Header bytes in big-endian stream order, packed four per word, low lane first.
    function automatic logic [31:0] exp_hdr(input int w, input logic [31:0] rc, input logic [31:0] old2);
        logic [7:0] bytes [12];
        logic [31:0] o;
        bytes[0] = TAG >> 8;   bytes[1] = TAG[7:0];
        bytes[2] = 8'd0;       bytes[3] = 8'd0; bytes[4] = 8'd0; bytes[5] = 8'd10;
        bytes[6] = rc >> 24;   bytes[7] = rc >> 16; bytes[8] = rc >> 8; bytes[9] = rc[7:0];
        bytes[10] = old2 >> 16; bytes[11] = old2 >> 24;
        o = {bytes[4*w+3], bytes[4*w+2], bytes[4*w+1], bytes[4*w]};
        return o;
    endfunction

    task automatic pulse_done(input logic [31:0] rc);
        exec_done = 1'b1; exec_rc = rc;
        @(negedge clk);
        exec_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_chk("R1 loc state", 12'h000, 32'h80);
        rd_chk("R1 status", 12'h044, 32'h2);
        rd_chk("R1 request", 12'h040, 32'h0);
        rd_chk("R1 start", 12'h04C, 32'h0);
        rd_chk("R1 cancel", 12'h048, 32'h0);

        // R3 writes without locality are dropped
        wr(12'h040, 32'h1);
        rd_chk("R3 request no loc", 12'h040, 32'h0);
        rd_chk("R3 status no loc", 12'h044, 32'h2);
        wr(12'h04C, 32'h1);
        rd_chk("R3 start no loc", 12'h04C, 32'h0);
        rd_chk("R3 no error", 12'h044, 32'h2);
        wr(12'h048, 32'h1);
        rd_chk("R3 cancel no loc", 12'h048, 32'h0);
        wr(12'h080, 32'h1234_5678);
        rd_chk("R3 buffer no loc", 12'h080, 32'h0);

        // R11 descriptor registers
        rd_chk("R11 if id", 12'h030, IFID);
        rd_chk("R11 cmd lo", 12'h05C, BASE + 32'h80);
        rd_chk("R11 rsp lo", 12'h068, BASE + 32'h80);
        rd_chk("R11 cmd hi", 12'h060, 32'h0);
        rd_chk("R11 rsp hi", 12'h06C, 32'h0);
        rd_chk("R11 cmd size", 12'h058, 32'(4 * WORDS));
        rd_chk("R11 rsp size", 12'h064, 32'(4 * WORDS));

        // R2 locality grant timing
        wr(12'h008, 32'h1);
        for (int i = 0; i < LLAT; i++) rd_chk("R2 pending", 12'h000, 32'h80);
        rd_chk("R2 granted", 12'h000, 32'h82);
        rd_chk("R2 loc status", 12'h00C, 32'h1);

        // R7 start while idle
        wr(12'h04C, 32'h1);
        rd_chk("R7 start ignored", 12'h04C, 32'h0);
        rd_chk("R7 error set", 12'h044, 32'h3);
        check("R7 busy low", 32'(exec_busy), 32'h0);
        // R5 go-idle in idle clears error
        wr(12'h040, 32'h2);
        rd_chk("R5 error cleared in idle", 12'h044, 32'h2);

        // R4 go-ready timing
        wr(12'h040, 32'h1);
        rd_chk("R4 idle cleared", 12'h044, 32'h0);
        for (int i = 1; i < SLAT; i++) rd_chk("R4 ready pending", 12'h040, 32'h1);
        rd_chk("R4 ready reached", 12'h040, 32'h0);

        // R10 random buffer traffic
        for (int i = 0; i < 24; i++) begin
            int idx;
            logic [31:0] d;
            idx = $urandom_range(WORDS - 1);
            d = $urandom;
            wr(12'(12'h080 + 4 * idx), d);
            model[idx] = d;
            idx = $urandom_range(WORDS - 1);
            rd_chk("R10 buffer", 12'(12'h080 + 4 * idx), model[idx]);
        end

        // R6 / R9 commands with random return codes
        for (int n = 0; n < 4; n++) begin
            logic [31:0] rc, old2;
            rc = (n == 0) ? 32'h0 : $urandom;
            old2 = $urandom;
            wr(12'h088, old2);
            wr(12'h04C, 32'h1);
            rd_chk("R6 start set", 12'h04C, 32'h1);
            check("R6 busy high", 32'(exec_busy), 32'h1);
            repeat ($urandom_range(3)) @(negedge clk);
            rd_chk("R6 still running", 12'h04C, 32'h1);
            pulse_done(rc);
            check("R6 busy low after done", 32'(exec_busy), 32'h0);
            rd_chk("R6 start cleared", 12'h04C, 32'h0);
            rd_chk("R6 ready no error", 12'h044, 32'h0);
            for (int w = 0; w < 3; w++)
                rd_chk("R9 header", 12'(12'h080 + 4 * w), exp_hdr(w, rc, old2));
            model[0] = exp_hdr(0, rc, old2);
        end

        // R12 go-idle during execution, R7 start during execution
        wr(12'h04C, 32'h1);
        wr(12'h040, 32'h2);
        rd_chk("R12 request ignored", 12'h040, 32'h0);
        rd_chk("R12 still running", 12'h04C, 32'h1);
        wr(12'h04C, 32'h1);
        rd_chk("R7 error while running", 12'h044, 32'h1);

        // R8 cancel ends execution without header
        wr(12'h048, 32'h1);
        rd_chk("R8 cancel reads 1", 12'h048, 32'h1);
        rd_chk("R8 start cleared", 12'h04C, 32'h0);
        check("R8 cancel pin", 32'(exec_cancel), 32'h1);
        rd_chk("R8 no header", 12'h080, model[0]);
        wr(12'h048, 32'h0);
        rd_chk("R8 cancel cleared", 12'h048, 32'h0);
        check("R8 cancel pin low", 32'(exec_cancel), 32'h0);

        // R5 go-idle timing and error clear
        wr(12'h040, 32'h2);
        for (int i = 0; i < SLAT; i++) rd_chk("R5 idle pending", 12'h040, 32'h2);
        rd_chk("R5 idle reached", 12'h044, 32'h2);

        // R2 release
        wr(12'h008, 32'h2);
        rd_chk("R2 released", 12'h000, 32'h80);
        rd_chk("R2 loc status low", 12'h00C, 32'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule